// File: doc/BRIEF.md
# Quasi-Bidirectional Port Controller

This block holds two 8-bit general-purpose ports and changes them in response to already-decoded host command codes, with one data byte where the command needs one. Port A is an open-drain, quasi-bidirectional port. A stored 0 pulls the pin low. A stored 1 releases the pin, and on the cycle the bit goes from 0 to 1 the pin is also driven strongly high for exactly one clock, so an external pull-up can then hold it high. Port B drives output levels. Bit 0 of port B drives the system reset line, so every change on that bit reaches its pin only after a fixed delay.

Port B can also be pulsed low for a fixed interval. A second pulse request that arrives while one is running waits in a one-deep slot. Both ports are read back through registered samples of their pins, so the host sees what is actually on the wire and not what was written. The host-side decoder that sits in front of this block passes a command strobe, the command code and a data byte.

Top module: `quasiPortUnit`

## Requirements
- R1: After reset, port A drives no bit low and no bit high, every port B output is 1, and control of port B bits 2 and 3 by the whole-byte write is enabled.
- R2: Codes B0h–BFh change one bit on the clock edge that accepts them. Bit 3 of the code gives the new value (0 clears, 1 sets). Code bits 2:0 select the target: 0–3 are A[0]–A[3], 4 is B[2], 5 is B[3], 6 is A[4], and 7 is A[5].
- R3: Codes 90h–9Fh copy code bits 3:0 into A[3:0] and leave A[7:4] unchanged.
- R4: Code D1h writes the data byte to port B. Bits 3:2 are written only while the gate is enabled. C8h enables the gate and C9h disables it.
- R5: Codes E0h–EFh copy code bits 3:1 into B[3:1] and leave every other bit unchanged.
- R6: Codes F0h–FFh pulse port B. Each B[i] for i=0..3 whose code bit i is 0 is forced low for PULSE_LEN cycles, starting in the cycle after the accepting edge. After that the stored level returns and the stored value is left unchanged.
- R7: A pulse code accepted while a pulse is running is held in a one-deep slot, and a later one overwrites it. The held pulse starts one cycle after the running pulse ends.
- R8: The B[0] pin follows its requested level, which includes pulses, exactly RST_DLY cycles later than the other port B pins would.
- R9: A port A bit drives low exactly while its stored value is 0. The cycle after it changes from 0 to 1, its strong-high output is 1 for one cycle only. Writing 1 to a bit that is already 1 gives no strong-high cycle.
- R10: rdA and rdB show the paPin and pbPin levels registered one cycle earlier, independent of the written values.
- R11: Command codes outside the sets above leave both ports unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, one cycle per command |
| cmdCode | input | 8 | Decoded command code |
| cmdData | input | 8 | Data byte for the whole-byte write |
| paPin | input | 8 | Sensed level of the port A pins |
| pbPin | input | 8 | Sensed level of the port B pins |
| paDrvLow | output | 8 | Port A pull-low enables |
| paDrvHigh | output | 8 | Port A one-cycle strong-high enables |
| pbOut | output | 8 | Port B output levels, bit 0 delayed |
| rdA | output | 8 | Registered readback of port A pins |
| rdB | output | 8 | Registered readback of port B pins |

## Verification
A wrong stored bit shows on paDrvLow or on pbOut[7:1] in the cycle right after the accepting edge. The same wrong bit shows on pbOut[0] exactly RST_DLY cycles later, so the bench samples at both points. A faulty pulse timer or a faulty pending slot shows as a pulse whose length or gap is off by a cycle, or as a held pulse that starts too early. The bench watches these at cycle resolution. A missing or doubled strong-high cycle on port A shows within one cycle of a release.

// File: rtl/quasiPortPkg.sv
package quasiPortPkg;

  typedef struct packed {
    logic [7:0] aSet;
    logic [7:0] aClr;
    logic [7:0] bSet;
    logic [7:0] bClr;
    logic [3:0] bPulse;
  } portStb_t;

  // Single-bit command index -> {onPortB, bitPosition}
  function automatic logic [3:0] bitSlot(input logic [2:0] idx);
    case (idx)
      3'd4:    bitSlot = {1'b1, 3'd2};
      3'd5:    bitSlot = {1'b1, 3'd3};
      3'd6:    bitSlot = {1'b0, 3'd4};
      3'd7:    bitSlot = {1'b0, 3'd5};
      default: bitSlot = {1'b0, idx};
    endcase
  endfunction

endpackage

// File: rtl/quasiPortCtrl.sv
module quasiPortCtrl
  import quasiPortPkg::*;
#(
  parameter int PULSE_LEN = 48
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdCode,
  input  logic [7:0] cmdData,
  output portStb_t   stb
);
  localparam int CW = $clog2(PULSE_LEN + 1);

  logic          gateEn;
  logic          pulseActive;
  logic          pendValid;
  logic [3:0]    pulseMask;
  logic [3:0]    pendMask;
  logic [CW-1:0] pulseCnt;
  logic          isPulse;
  logic [3:0]    slot;
  logic [7:0]    oneHot;
  logic [7:0]    wrMask;

  assign isPulse = cmdValid && (cmdCode[7:4] == 4'hF);
  assign slot    = bitSlot(cmdCode[2:0]);
  assign oneHot  = 8'(1) << slot[2:0];
  assign wrMask  = gateEn ? 8'hFF : 8'hF3;

  always_comb begin
    stb = '0;
    if (cmdValid) begin
      case (cmdCode[7:4])
        4'hB: begin
          if (slot[3]) begin
            if (cmdCode[3]) stb.bSet = oneHot;
            else            stb.bClr = oneHot;
          end else begin
            if (cmdCode[3]) stb.aSet = oneHot;
            else            stb.aClr = oneHot;
          end
        end
        4'h9: begin
          stb.aSet[3:0] = cmdCode[3:0];
          stb.aClr[3:0] = ~cmdCode[3:0];
        end
        4'hD: begin
          if (cmdCode[3:0] == 4'h1) begin
            stb.bSet = cmdData & wrMask;
            stb.bClr = ~cmdData & wrMask;
          end
        end
        4'hE: begin
          stb.bSet[3:1] = cmdCode[3:1];
          stb.bClr[3:1] = ~cmdCode[3:1];
        end
        default: ;
      endcase
    end
    stb.bPulse = pulseMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gateEn <= 1'b1;
    end else if (cmdValid && cmdCode == 8'hC8) begin
      gateEn <= 1'b1;
    end else if (cmdValid && cmdCode == 8'hC9) begin
      gateEn <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseActive <= 1'b0;
      pendValid   <= 1'b0;
      pulseMask   <= '0;
      pendMask    <= '0;
      pulseCnt    <= '0;
    end else if (pulseActive) begin
      if (pulseCnt == '0) begin
        pulseActive <= 1'b0;
        pulseMask   <= '0;
      end else begin
        pulseCnt <= pulseCnt - 1'b1;
      end
      if (isPulse) begin
        pendValid <= 1'b1;
        pendMask  <= ~cmdCode[3:0];
      end
    end else if (pendValid) begin
      pulseActive <= 1'b1;
      pulseMask   <= pendMask;
      pulseCnt    <= CW'(PULSE_LEN - 1);
      if (isPulse) pendMask <= ~cmdCode[3:0];
      else         pendValid <= 1'b0;
    end else if (isPulse) begin
      pulseActive <= 1'b1;
      pulseMask   <= ~cmdCode[3:0];
      pulseCnt    <= CW'(PULSE_LEN - 1);
    end
  end

  // R2
  set_clr_disjoint_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((stb.aSet & stb.aClr) == '0) && ((stb.bSet & stb.bClr) == '0));

  // R4
  gate_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == 8'hD1 && !gateEn) |-> ((stb.bSet[3:2] | stb.bClr[3:2]) == 2'b00));

  // R6
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pulseActive && pulseCnt == '0) |=> (!pulseActive && pulseMask == '0));

  // R7
  pend_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pulseActive && isPulse) |=> pendValid);

endmodule

// File: rtl/quasiPortData.sv
module quasiPortData
  import quasiPortPkg::*;
#(
  parameter int RST_DLY = 48
) (
  input  logic       clk,
  input  logic       rstN,
  input  portStb_t   stb,
  input  logic [7:0] paPin,
  input  logic [7:0] pbPin,
  output logic [7:0] paDrvLow,
  output logic [7:0] paDrvHigh,
  output logic [7:0] pbOut,
  output logic [7:0] rdA,
  output logic [7:0] rdB
);
  logic [7:0] paReg, pbReg, paKick;
  logic [7:0] paNext, pbNext, bReq;
  logic       dlOut;

  assign paNext = (paReg & ~stb.aClr) | stb.aSet;
  assign pbNext = (pbReg & ~stb.bClr) | stb.bSet;
  assign bReq   = pbReg & ~{4'b0000, stb.bPulse};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      paReg  <= 8'hFF;
      pbReg  <= 8'hFF;
      paKick <= '0;
      rdA    <= '0;
      rdB    <= '0;
    end else begin
      paReg  <= paNext;
      pbReg  <= pbNext;
      paKick <= paNext & ~paReg;
      rdA    <= paPin;
      rdB    <= pbPin;
    end
  end

  generate
    if (RST_DLY == 1) begin : g_dlyOne
      always_ff @(posedge clk) begin
        if (!rstN) dlOut <= 1'b1;
        else       dlOut <= bReq[0];
      end
    end else begin : g_dlyChain
      logic [RST_DLY-1:0] dl;
      always_ff @(posedge clk) begin
        if (!rstN) dl <= '1;
        else       dl <= {dl[RST_DLY-2:0], bReq[0]};
      end
      assign dlOut = dl[RST_DLY-1];
    end
  endgenerate

  assign paDrvLow  = ~paReg;
  assign paDrvHigh = paKick;
  assign pbOut     = {bReq[7:1], dlOut};

  // R9
  kick_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (paKick != '0) |=> ((paKick & $past(paKick)) == '0));

  // R9
  kick_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    (paKick != '0) |-> ((paKick & paDrvLow) == '0));

  // R10
  readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    $stable(paPin) && $stable(pbPin) |=> (rdA == $past(paPin) && rdB == $past(pbPin)));

endmodule

// File: rtl/quasiPortUnit.sv
module quasiPortUnit
  import quasiPortPkg::*;
#(
  parameter int PULSE_LEN = 48,
  parameter int RST_DLY   = 48
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdCode,
  input  logic [7:0] cmdData,
  input  logic [7:0] paPin,
  input  logic [7:0] pbPin,
  output logic [7:0] paDrvLow,
  output logic [7:0] paDrvHigh,
  output logic [7:0] pbOut,
  output logic [7:0] rdA,
  output logic [7:0] rdB
);
  portStb_t stb;

  quasiPortCtrl #(.PULSE_LEN(PULSE_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdData(cmdData), .stb(stb)
  );

  quasiPortData #(.RST_DLY(RST_DLY)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .paPin(paPin), .pbPin(pbPin),
    .paDrvLow(paDrvLow), .paDrvHigh(paDrvHigh), .pbOut(pbOut),
    .rdA(rdA), .rdB(rdB)
  );

endmodule

// File: tb/quasiPortUnit_test.sv
`timescale 1ns/1ps
module quasiPortUnit_test;
  localparam int PL = 48;
  localparam int RD = 48;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN, cmdValid;
  logic [7:0] cmdCode, cmdData, paPin, pbPin;
  logic [7:0] paDrvLow, paDrvHigh, pbOut, rdA, rdB;

  quasiPortUnit #(.PULSE_LEN(PL), .RST_DLY(RD)) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdData(cmdData), .paPin(paPin), .pbPin(pbPin), .paDrvLow(paDrvLow),
    .paDrvHigh(paDrvHigh), .pbOut(pbOut), .rdA(rdA), .rdB(rdB)
  );

  int nChk = 0;
  int nBad = 0;
  logic [7:0] mA = 8'hFF, mB = 8'hFF;
  logic       mGate = 1'b1;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [7:0] code, input logic [7:0] data);
    case (code[7:4])
      4'hB: case (code[2:0])
              3'd4: mB[2] = code[3];
              3'd5: mB[3] = code[3];
              3'd6: mA[4] = code[3];
              3'd7: mA[5] = code[3];
              default: mA[code[2:0]] = code[3];
            endcase
      4'h9: mA[3:0] = code[3:0];
      4'hD: if (code == 8'hD1) begin
              mB[7:4] = data[7:4];
              mB[1:0] = data[1:0];
              if (mGate) mB[3:2] = data[3:2];
            end
      4'hE: mB[3:1] = code[3:1];
      4'hC: if (code == 8'hC8) mGate = 1'b1;
            else if (code == 8'hC9) mGate = 1'b0;
      default: ;
    endcase
  endfunction

  // Ends at the negedge right after the accepting edge
  task automatic sendCmd(input logic [7:0] code, input logic [7:0] data);
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = code; cmdData = data;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic doCmd(input logic [7:0] code, input logic [7:0] data, input string req);
    logic [7:0] oldA;
    oldA = mA;
    model(code, data);
    sendCmd(code, data);
    chk({req, " drive-low"}, paDrvLow, ~mA);
    chk({req, " port B 7:1"}, {pbOut[7:1], 1'b0}, {mB[7:1], 1'b0});
    chk({req, " R9 strong-high"}, paDrvHigh, mA & ~oldA);
    repeat (RD) @(negedge clk);
    chk({req, " R8 port B delayed"}, pbOut, mB);
    chk({req, " R9 strong-high off"}, paDrvHigh, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rstN = 1'b0; cmdValid = 1'b0; cmdCode = '0; cmdData = '0;
    paPin = 8'hFF; pbPin = 8'hFF;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 drive-low", paDrvLow, 8'h00);
    chk("R1 strong-high", paDrvHigh, 8'h00);
    chk("R1 port B", pbOut, 8'hFF);

    // R2 single bits, index map
    doCmd(8'hB0, 8'h00, "R2 clr A0");
    chk("R2 A0 low", paDrvLow, 8'h01);
    doCmd(8'hB4, 8'h00, "R2 clr B2");
    chk("R2 B2 low", pbOut, 8'hFB);
    doCmd(8'hB6, 8'h00, "R2 clr A4");
    doCmd(8'hB7, 8'h00, "R2 clr A5");
    chk("R2 A4 A5 low", paDrvLow, 8'h31);
    doCmd(8'hBC, 8'h00, "R2 set B2");
    // R9 release gives one strong-high cycle
    model(8'hB8, 8'h00);
    sendCmd(8'hB8, 8'h00);
    chk("R9 kick on release", paDrvHigh, 8'h01);
    @(negedge clk);
    chk("R9 kick gone", paDrvHigh, 8'h00);
    sendCmd(8'hB8, 8'h00);
    chk("R9 no kick when already 1", paDrvHigh, 8'h00);

    // R3 nibble write
    doCmd(8'h95, 8'h00, "R3 nibble");
    chk("R3 A value", paDrvLow, 8'h3A);
    doCmd(8'h9F, 8'h00, "R3 nibble all ones");

    // R4 gate
    doCmd(8'hC9, 8'h00, "R4 gate off");
    doCmd(8'hD1, 8'h00, "R4 write gated");
    chk("R4 bits 3:2 kept", pbOut, 8'h0C);
    doCmd(8'hC8, 8'h00, "R4 gate on");
    doCmd(8'hD1, 8'h00, "R4 write open");
    chk("R4 all written", pbOut, 8'h00);
    doCmd(8'hD1, 8'hFF, "R4 restore");

    // R5 level nibble
    doCmd(8'hE4, 8'h00, "R5 E4");
    chk("R5 bits 3:1", pbOut, 8'hF5);
    doCmd(8'hEE, 8'h00, "R5 EE");

    // R11 ignored codes
    doCmd(8'h20, 8'h00, "R11 code 20");
    doCmd(8'hA7, 8'h00, "R11 code A7");
    doCmd(8'hD2, 8'h00, "R11 code D2");
    chk("R11 port B unchanged", pbOut, 8'hFF);
    chk("R11 port A unchanged", paDrvLow, 8'h30);

    // R8 delay of reset bit
    model(8'hD1, 8'hFE);
    sendCmd(8'hD1, 8'hFE);
    repeat (RD - 1) @(negedge clk);
    chk("R8 bit0 not yet", pbOut, 8'hFF);
    @(negedge clk);
    chk("R8 bit0 after delay", pbOut, 8'hFE);
    doCmd(8'hD1, 8'hFF, "R8 restore");

    // R6 pulse length
    sendCmd(8'hFD, 8'h00);
    chk("R6 pulse start", pbOut, 8'hFD);
    repeat (PL - 1) @(negedge clk);
    chk("R6 pulse last", pbOut, 8'hFD);
    @(negedge clk);
    chk("R6 pulse over", pbOut, 8'hFF);

    // R7 back-to-back pulse held
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = 8'hFD;
    @(negedge clk);
    cmdCode = 8'hFB;
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R7 second held", pbOut, 8'hFD);
    repeat (PL - 2) @(negedge clk);
    chk("R7 first last cycle", pbOut, 8'hFD);
    @(negedge clk);
    chk("R7 gap cycle", pbOut, 8'hFF);
    @(negedge clk);
    chk("R7 second starts", pbOut, 8'hFB);
    repeat (PL - 1) @(negedge clk);
    chk("R7 second last", pbOut, 8'hFB);
    @(negedge clk);
    chk("R7 second over", pbOut, 8'hFF);

    // R8 pulse on reset bit is delayed
    sendCmd(8'hFE, 8'h00);
    repeat (RD - 1) @(negedge clk);
    chk("R8 pulse not yet", pbOut, 8'hFF);
    @(negedge clk);
    chk("R8 pulse arrives", pbOut, 8'hFE);
    repeat (PL - 1) @(negedge clk);
    chk("R8 pulse last", pbOut, 8'hFE);
    @(negedge clk);
    chk("R8 pulse over", pbOut, 8'hFF);

    // R10 readback follows pins, not written values
    paPin = 8'h5A; pbPin = 8'hC3;
    @(negedge clk);
    chk("R10 rdA", rdA, 8'h5A);
    chk("R10 rdB", rdB, 8'hC3);
    paPin = 8'h00;
    @(negedge clk);
    chk("R10 rdA external low", rdA, 8'h00);
    paPin = 8'hFF; pbPin = 8'hFF;

    // Random mix
    for (int i = 0; i < 150; i++) begin
      logic [7:0] c, d;
      d = 8'($urandom);
      case ($urandom % 6)
        0: c = {4'hB, 4'($urandom)};
        1: c = {4'h9, 4'($urandom)};
        2: c = 8'hD1;
        3: c = {4'hE, 4'($urandom)};
        4: c = ($urandom % 2) ? 8'hC8 : 8'hC9;
        default: c = 8'($urandom);
      endcase
      if (c[7:4] == 4'hF) c = 8'hA1;
      doCmd(c, d, "R2 R3 R4 R5 R11 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule